// File: doc/BRIEF.md
# AES3 Channel-Status Block Framer with C/U/V Capture

This block sits in front of an AES3 biphase encoder and decides, subframe by subframe, which channel-status (C), user (U) and validity (V) bits go out and where the 192-frame channel-status block begins. Each change of the left/right word clock starts a new subframe. The word clock is brought into the master-clock domain, its edges are detected, and a subframe counter running from 0 to 383 advances on each edge. Index 0 marks the first subframe of a block. On the same edge the block latches the three bits for that subframe and raises `sub_stb` for one master-clock cycle.

Two capture modes are selected by `mode_b`. In mode A, U and V are taken from their pins on each subframe. C comes from a 192-bit consumer status image that is built from four static pins and indexed by frame number. In mode B, all three bits are shifted in serially from their pins, one per subframe. The block-start pin works in one of two directions, chosen by `blk_dir`. As an output it is high for the whole first subframe of every block. As an input it is a synchronisation request: a high level lasting at least `MIN_PULSE` master clocks forces the next subframe to become index 0.

The request qualifier is a state machine with four states. IDLE waits for a high request. COUNT measures the high run. ARMED holds a qualified request until the next subframe consumes it. WAIT_LOW refuses to re-arm until the request line falls. The transitions are as follows:
- IDLE→COUNT when the request goes high.
- COUNT→IDLE when the request drops early.
- COUNT→ARMED once the high run reaches `MIN_PULSE`.
- ARMED→WAIT_LOW when a subframe starts while the request is still high.
- ARMED→IDLE when a subframe starts with the request low.
- WAIT_LOW→IDLE when the request falls.
- Any state→IDLE while `blk_dir` selects output direction.

Top module: `cs_block_framer`

## Requirements
- R1: While `rst_n` is low, `sub_stb`, `sf_start`, `c_out`, `u_out`, `v_out` and `blk_out` are 0. The first subframe after reset is index 0, so `sf_start` is 1 for it.
- R2: Every change of `wclk` (rising or falling) produces exactly one `sub_stb` pulse, one master clock long. If `wclk` changes just after a master-clock rising edge, the pulse is high after the third rising edge that follows.
- R3: The subframe index steps by one per subframe and wraps from 383 to 0. `sf_start` is 1 only for index 0, so block starts are 384 subframes apart unless a sync request intervenes.
- R4: On each subframe, `u_out` and `v_out` take the values of `u_in` and `v_in` present at the capturing clock edge, in both modes.
- R5: With `mode_b`=0, `c_out` is bit number (index/2) of a status image. In that image, bit 1 = `nonaudio`, bit 2 = `copy_ok`, bit 3 = `emph`, bit 16 = `orig`, and every other bit is 0. Bits 8–15 form the category code, which is therefore 00h. Bit 0 is 0, meaning consumer format.
- R6: With `mode_b`=1, `c_out` takes the value of `c_in` present at the capturing clock edge.
- R7: `blk_oe` equals `blk_dir`. When `blk_dir`=1, `blk_out` is high from the strobe of subframe 0 until the next strobe and low otherwise. When `blk_dir`=0, `blk_out` is 0.
- R8: When `blk_dir`=0 and `blk_in` stays high for 3 or more consecutive master clocks, the next subframe is index 0 with `sf_start`=1, and counting continues from there.
- R9: A `blk_in` high run of 2 master clocks or fewer, or any `blk_in` activity while `blk_dir`=1, leaves the subframe sequence unchanged.
- R10: A `blk_in` level held high across many subframes forces only one block restart. A further restart needs the line to fall and rise again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk | input | 1 | Left/right word clock, asynchronous to `clk` |
| mode_b | input | 1 | 0 = mode A (static status pins), 1 = mode B (serial C) |
| copy_ok | input | 1 | Mode A: copy-permitted status bit |
| orig | input | 1 | Mode A: original-generation status bit |
| emph | input | 1 | Mode A: pre-emphasis status bit |
| nonaudio | input | 1 | Mode A: non-audio status bit |
| c_in | input | 1 | Mode B serial channel-status data |
| u_in | input | 1 | Serial user data |
| v_in | input | 1 | Serial validity data |
| blk_dir | input | 1 | 1 = block-start pin driven by the block, 0 = sampled as sync request |
| blk_in | input | 1 | Block-start pin level, used as the sync request |
| blk_out | output | 1 | Block-start pin drive value |
| blk_oe | output | 1 | Block-start pin drive enable |
| sub_stb | output | 1 | One-cycle strobe: new subframe bits are valid |
| c_out | output | 1 | Channel-status bit for the current subframe |
| u_out | output | 1 | User bit for the current subframe |
| v_out | output | 1 | Validity bit for the current subframe |
| sf_start | output | 1 | Current subframe is the first of a block |

## Verification
The assertions check the following on every cycle:
- The subframe index stays in range, holds between strobes and climbs by one except at index 0.
- Captured U, V and mode-B C bits match the pins at the strobe edge.
- An armed request makes the next subframe index 0.
- The qualifier never arms straight from IDLE.
- The category field of the status image is zero.

The behaviours that unfold over many cycles can only be shown by the bench scenarios. These are the three-edge strobe latency, full 384-subframe blocks, the mode-A status mapping across a block, and the difference between a 2-cycle and a 3-cycle request pulse. They also include a request held across several subframes and a request ignored in output direction. All of these are compared against a cycle-by-cycle reference model.

// File: rtl/cs_frame_pkg.sv
package cs_frame_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_COUNT,
        SQ_ARMED,
        SQ_WAIT_LOW
    } sync_state_e;

    typedef struct packed {
        logic c;
        logic u;
        logic v;
    } cuv_t;

endpackage

// File: rtl/cs_sync_chain.sv
module cs_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] stage_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[gi] <= 1'b0;
                    else        stage_q[gi] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[gi] <= 1'b0;
                    else        stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/cs_sync_qual.sv
module cs_sync_qual
    import cs_frame_pkg::*;
#(
    parameter int unsigned MIN_PULSE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic req,
    input  logic consume,
    output logic armed
);
    localparam int unsigned CW = $clog2(MIN_PULSE + 1);

    sync_state_e   state_q, state_d;
    logic [CW-1:0] run_q, run_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (!enable) begin
            state_d = SQ_IDLE;
            run_d   = '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (req) begin
                        run_d   = CW'(1);
                        state_d = (MIN_PULSE <= 1) ? SQ_ARMED : SQ_COUNT;
                    end
                end
                SQ_COUNT: begin
                    if (!req) begin
                        state_d = SQ_IDLE;
                        run_d   = '0;
                    end else if (int'(run_q) + 1 >= int'(MIN_PULSE)) begin
                        state_d = SQ_ARMED;
                        run_d   = '0;
                    end else begin
                        run_d = run_q + CW'(1);
                    end
                end
                SQ_ARMED: begin
                    if (consume) state_d = req ? SQ_WAIT_LOW : SQ_IDLE;
                end
                SQ_WAIT_LOW: begin
                    if (!req) state_d = SQ_IDLE;
                end
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        armed = (state_q == SQ_ARMED);
    end

    generate
        if (MIN_PULSE >= 2) begin : g_short_chk
            // R9
            no_short_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(state_q) == SQ_IDLE) |-> (state_q != SQ_ARMED));
        end
    endgenerate

    // R10
    no_rearm_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WAIT_LOW && req) |=> (state_q != SQ_ARMED));

endmodule

// File: rtl/cs_status_image.sv
module cs_status_image #(
    parameter int unsigned FRAMES = 192
) (
    input  logic                      copy_ok,
    input  logic                      orig,
    input  logic                      emph,
    input  logic                      nonaudio,
    input  logic [$clog2(FRAMES)-1:0] frame_idx,
    output logic                      c_bit
);
    logic [FRAMES-1:0] image;

    always_comb begin
        image     = '0;
        image[1]  = nonaudio;
        image[2]  = copy_ok;
        image[3]  = emph;
        image[16] = orig;
        c_bit     = image[frame_idx];
    end

    always_comb begin
        if (frame_idx >= 8 && frame_idx <= 15) begin
            // R5
            category_zero_chk: assert (!c_bit);
        end
    end
endmodule

// File: rtl/cs_block_framer.sv
module cs_block_framer
    import cs_frame_pkg::*;
#(
    parameter int unsigned SUBFRAMES   = 384,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_PULSE   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk,
    input  logic mode_b,
    input  logic copy_ok,
    input  logic orig,
    input  logic emph,
    input  logic nonaudio,
    input  logic c_in,
    input  logic u_in,
    input  logic v_in,
    input  logic blk_dir,
    input  logic blk_in,
    output logic blk_out,
    output logic blk_oe,
    output logic sub_stb,
    output logic c_out,
    output logic u_out,
    output logic v_out,
    output logic sf_start
);
    localparam int unsigned FRAMES = SUBFRAMES / 2;
    localparam int unsigned CNT_W  = $clog2(SUBFRAMES);
    localparam int unsigned FRM_W  = $clog2(FRAMES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SUBFRAMES - 1);

    logic             wclk_s, wclk_d, wc_edge;
    logic             blk_s, sync_req;
    logic [CNT_W-1:0] sf_cnt, nxt_idx;
    logic [FRM_W-1:0] frame_idx;
    logic             img_bit;
    cuv_t             cuv_q;

    cs_sync_chain #(.STAGES(SYNC_STAGES)) u_wclk_sync (
        .clk(clk), .rst_n(rst_n), .async_in(wclk), .sync_out(wclk_s)
    );

    cs_sync_chain #(.STAGES(SYNC_STAGES)) u_blk_sync (
        .clk(clk), .rst_n(rst_n), .async_in(blk_in), .sync_out(blk_s)
    );

    cs_sync_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
        .clk(clk), .rst_n(rst_n), .enable(!blk_dir), .req(blk_s),
        .consume(wc_edge), .armed(sync_req)
    );

    always_comb begin
        wc_edge = wclk_s ^ wclk_d;
        if (sync_req || sf_cnt == LAST_IDX) nxt_idx = '0;
        else                                nxt_idx = sf_cnt + CNT_W'(1);
        frame_idx = FRM_W'(nxt_idx >> 1);
    end

    cs_status_image #(.FRAMES(FRAMES)) u_image (
        .copy_ok(copy_ok), .orig(orig), .emph(emph), .nonaudio(nonaudio),
        .frame_idx(frame_idx), .c_bit(img_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wclk_d   <= 1'b0;
            sub_stb  <= 1'b0;
            sf_cnt   <= LAST_IDX;
            sf_start <= 1'b0;
            cuv_q    <= '0;
        end else begin
            wclk_d  <= wclk_s;
            sub_stb <= wc_edge;
            if (wc_edge) begin
                sf_cnt   <= nxt_idx;
                sf_start <= (nxt_idx == '0);
                cuv_q.c  <= mode_b ? c_in : img_bit;
                cuv_q.u  <= u_in;
                cuv_q.v  <= v_in;
            end
        end
    end

    always_comb begin
        c_out   = cuv_q.c;
        u_out   = cuv_q.u;
        v_out   = cuv_q.v;
        blk_oe  = blk_dir;
        blk_out = blk_dir & sf_start;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sf_cnt < CNT_W'(SUBFRAMES));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_stb && sf_cnt != '0) |-> (sf_cnt == $past(sf_cnt) + CNT_W'(1)));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_stb |-> $stable(sf_cnt));

    // R4
    user_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_stb |-> (u_out == $past(u_in) && v_out == $past(v_in)));

    // R6
    modeb_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_stb && $past(mode_b)) |-> (c_out == $past(c_in)));

    // R7
    blk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_oe |-> !blk_out);

    // R8
    sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && wc_edge) |=> (sf_cnt == '0 && sf_start));

endmodule

// File: tb/tb_cs_block_framer.sv
module tb_cs_block_framer;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wclk = 1'b0, mode_b = 1'b0;
    logic copy_ok = 1'b0, orig = 1'b0, emph = 1'b0, nonaudio = 1'b0;
    logic c_in = 1'b0, u_in = 1'b0, v_in = 1'b0;
    logic blk_dir = 1'b1, blk_in = 1'b0;
    logic blk_out, blk_oe, sub_stb, c_out, u_out, v_out, sf_start;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cs_block_framer dut (
        .clk(clk), .rst_n(rst_n), .wclk(wclk), .mode_b(mode_b),
        .copy_ok(copy_ok), .orig(orig), .emph(emph), .nonaudio(nonaudio),
        .c_in(c_in), .u_in(u_in), .v_in(v_in), .blk_dir(blk_dir), .blk_in(blk_in),
        .blk_out(blk_out), .blk_oe(blk_oe), .sub_stb(sub_stb), .c_out(c_out),
        .u_out(u_out), .v_out(v_out), .sf_start(sf_start)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit img_ref(input int f);
        case (f)
            1:  return nonaudio;
            2:  return copy_ok;
            3:  return emph;
            16: return orig;
            default: return 1'b0;
        endcase
    endfunction

    // ---------------- reference model ----------------
    int  wq[$];
    int  bq[$];
    int  m_cnt;
    bit  m_armed, m_waitlow;
    int  m_run;
    bit  e_stb, e_start, e_c, e_u, e_v;

    always @(posedge clk) begin
        if (!rst_n) begin
            wq = '{0, 0, 0};
            bq = '{0, 0, 0};
            m_cnt = 383; m_armed = 0; m_waitlow = 0; m_run = 0;
            e_stb = 0; e_start = 0; e_c = 0; e_u = 0; e_v = 0;
        end else begin
            bit stb;
            bit req;
            stb = (wq[$-1] != wq[$-2]);
            req = (bq[$-1] != 0);
            e_stb = stb;
            if (stb) begin
                int nidx;
                nidx = m_armed ? 0 : ((m_cnt == 383) ? 0 : m_cnt + 1);
                m_cnt = nidx;
                e_start = (nidx == 0);
                e_c = mode_b ? c_in : img_ref(nidx / 2);
                e_u = u_in;
                e_v = v_in;
            end
            if (blk_dir) begin
                m_armed = 0; m_waitlow = 0; m_run = 0;
            end else if (m_armed) begin
                if (stb) begin
                    m_armed = 0; m_waitlow = req; m_run = 0;
                end
            end else if (m_waitlow) begin
                if (!req) m_waitlow = 0;
            end else begin
                m_run = req ? m_run + 1 : 0;
                if (m_run >= 3) begin
                    m_armed = 1; m_run = 0;
                end
            end
            wq.push_back(int'(wclk));
            bq.push_back(int'(blk_in));
            if (wq.size() > 4) void'(wq.pop_front());
            if (bq.size() > 4) void'(bq.pop_front());
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(sub_stb == e_stb,   "R2 model sub_stb",  sub_stb,  e_stb);
            chk(sf_start == e_start, "R3 model sf_start", sf_start, e_start);
            chk(c_out == e_c,       mode_b ? "R6 model c_out" : "R5 model c_out", c_out, e_c);
            chk(u_out == e_u,       "R4 model u_out",    u_out,    e_u);
            chk(v_out == e_v,       "R4 model v_out",    v_out,    e_v);
            chk(blk_oe == blk_dir,  "R7 model blk_oe",   blk_oe,   blk_dir);
            chk(blk_out == (blk_dir & e_start), "R7 model blk_out", blk_out, blk_dir & e_start);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_sf(input bit c, input bit u, input bit v);
        @(negedge clk);
        c_in = c; u_in = u; v_in = v;
        wclk = ~wclk;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic send_sf_pulse(input bit c, input bit u, input bit v, input int n);
        @(negedge clk);
        c_in = c; u_in = u; v_in = v;
        wclk = ~wclk;
        repeat (4) @(negedge clk);
        blk_in = 1'b1;
        repeat (n) @(negedge clk);
        blk_in = 1'b0;
        repeat (HALF - 5 - n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(sub_stb == 0 && sf_start == 0, "R1 reset stb/start", {sub_stb, sf_start}, 0);
        chk(c_out == 0 && u_out == 0 && v_out == 0, "R1 reset cuv", {c_out, u_out, v_out}, 0);
        chk(blk_out == 0, "R1 reset blk_out", blk_out, 0);
        chk(blk_oe == 1, "R7 blk_oe follows dir", blk_oe, 1);
        rst_n = 1'b1;
        copy_ok = 1; orig = 1; emph = 1; nonaudio = 1;
        repeat (3) @(negedge clk);

        // R2 latency: strobe on third edge after the toggle
        @(negedge clk);
        u_in = 1; v_in = 0; c_in = 0;
        wclk = ~wclk;
        @(negedge clk); chk(sub_stb == 0, "R2 latency edge1", sub_stb, 0);
        @(negedge clk); chk(sub_stb == 0, "R2 latency edge2", sub_stb, 0);
        @(negedge clk); chk(sub_stb == 1, "R2 latency edge3", sub_stb, 1);
        @(negedge clk); chk(sub_stb == 0, "R2 single pulse", sub_stb, 0);
        chk(sf_start == 1, "R1 first subframe is block start", sf_start, 1);
        chk(u_out == 1, "R4 first u", u_out, 1);
        repeat (HALF - 4) @(negedge clk);

        // Mode A full block: index i after i further subframes
        for (int i = 1; i <= 386; i++) begin
            bit uu, vv;
            uu = 1'($urandom);
            vv = 1'($urandom);
            send_sf(1'b0, uu, vv);
            chk(u_out == uu && v_out == vv, "R4 mode A u/v", {u_out, v_out}, {uu, vv});
            if (i == 383) chk(sf_start == 0, "R3 index 383 not start", sf_start, 0);
            if (i == 384) chk(sf_start == 1, "R3 wrap to index 0", sf_start, 1);
            if (i == 384) chk(blk_out == 1, "R7 blk_out during first subframe", blk_out, 1);
            if (i == 385) chk(blk_out == 0, "R7 blk_out after first subframe", blk_out, 0);
            if (i == 2 || i == 3) chk(c_out == 1, "R5 nonaudio bit", c_out, 1);
            if (i == 32 || i == 33) chk(c_out == 1, "R5 orig bit", c_out, 1);
            if (i >= 16 && i <= 31) chk(c_out == 0, "R5 category zero", c_out, 0);
            if (i == 1) chk(c_out == 0, "R5 consumer bit0", c_out, 0);
        end

        // Mode B
        mode_b = 1'b1;
        for (int i = 0; i < 60; i++) begin
            bit cc;
            cc = 1'($urandom);
            send_sf(cc, 1'($urandom), 1'($urandom));
            chk(c_out == cc, "R6 mode B c", c_out, cc);
        end

        // Sync input direction
        blk_dir = 1'b0;
        send_sf(1, 0, 0);
        chk(blk_oe == 0, "R7 blk_oe low in input direction", blk_oe, 0);
        send_sf_pulse(0, 0, 0, 2);
        send_sf(0, 0, 0);
        chk(sf_start == 0, "R9 two-cycle pulse ignored", sf_start, 0);
        send_sf_pulse(0, 0, 0, 3);
        send_sf(0, 0, 0);
        chk(sf_start == 1, "R8 three-cycle pulse restarts", sf_start, 1);
        chk(blk_out == 0, "R7 blk_out low in input direction", blk_out, 0);
        send_sf(0, 0, 0);
        chk(sf_start == 0, "R8 count continues after restart", sf_start, 0);

        // R10 held high
        @(negedge clk);
        blk_in = 1'b1;
        repeat (5) @(negedge clk);
        send_sf(0, 0, 0);
        chk(sf_start == 1, "R10 held level restarts once", sf_start, 1);
        for (int i = 0; i < 4; i++) begin
            send_sf(0, 0, 0);
            chk(sf_start == 0, "R10 held level no second restart", sf_start, 0);
        end
        @(negedge clk);
        blk_in = 1'b0;
        repeat (3) @(negedge clk);

        // R9 output direction ignores requests
        blk_dir = 1'b1;
        send_sf(0, 0, 0);
        send_sf_pulse(0, 0, 0, 4);
        send_sf(0, 0, 0);
        chk(sf_start == 0, "R9 request ignored in output direction", sf_start, 0);
        send_sf(1, 1, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule